// File: doc/BRIEF.md
# Timer-Counter PWM Channel Bank

This block holds a set of independent timer channels, each of which drives one PWM pin. Every channel has a 16-bit up-counter, a duty compare value, a period compare value and a small control word. The control word holds three bits: an output enable, a select for the idle-phase (initial) pin level, and a select for abrupt shutdown. A counter advances by one on each pulse of its channel's clock-enable tick, but only while its run bit is set. The run bits are changed through two shared strobe addresses. Writing ones to the first address starts the selected counters, and writing ones to the second stops them. Reading the first address returns the run bits.

In each period the pin starts at the initial level. It flips to the opposite level once the counter reaches the duty value, and it holds that level through the period value. The counter then wraps to zero and the pin returns to the initial level. If the duty value is greater than the period value, the pin stays at the initial level for the whole period. Clearing the output enable either parks the pin at once (abrupt shutdown) or lets the current period run to its end first. All registers sit behind a plain synchronous bus with combinational read data.

Top module: `pwm_timer_bank`

## Requirements
- R1: After reset all channel registers read 0, every counter is stopped, the run status reads 0 and every pin is low.
- R2: A write to address 2^(AW-1) (set strobe) sets run bit n for each 1 in wdata bit n. A write to address 2^(AW-1)+1 (clear strobe) clears run bit n for each 1 in wdata bit n. Zero bits leave other channels alone. Reading the set address returns the run bits in bits NUM_CH-1:0.
- R3: A running counter advances by exactly one on each cycle where its own tick bit is high. A stopped counter, or one whose tick is low, holds its value.
- R4: When a running counter equals the period value, the next tick loads it with 0.
- R5: While the counter is below the duty value the pin shows the initial level. From the duty value through the period value it shows the inverse level.
- R6: Control bit 1 selects the initial level: 1 gives high, 0 gives low.
- R7: With control bit 0 (output enable) cleared and no shutdown drain pending, the pin shows the initial level whatever the counter holds.
- R8: Control bit 2 selects abrupt shutdown. A control write that clears bit 0 with bit 2 set parks the pin at the initial level in the next cycle. With bit 2 clear on a running channel, the pin keeps toggling until the counter wraps, and only then parks.
- R9: When the duty value exceeds the period value, the pin stays at the initial level over every count.
- R10: Channel n's counter can be written at word n*4+3. The written value replaces the count, so writing 0 restarts the period.
- R11: Channel n's registers read back at word addresses n*4+0 (control, bits 2:0), n*4+1 (duty), n*4+2 (period) and n*4+3 (count).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW (6) | Word address |
| bus_wdata | input | 16 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| tick | input | NUM_CH (8) | Per-channel count-enable pulses |
| pwm_out | output | NUM_CH (8) | Per-channel PWM pins |

## Verification
The waveform is first checked at every count of a duty-2, period-4 cycle with a low initial level. This separates the idle phase, the active phase and the wrap back to zero. The same counts are then run with a high initial level to show the polarity select is a true inversion, not a fixed phase. The two shutdown styles are each started in the middle of an active phase: only the abrupt one may park before the wrap, and only the soft one must keep toggling up to the wrap. Duty above period, stopped counters, ticks meant for other channels and counter rewrites each confirm that the pin or the count stays where the requirements say.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

  localparam int CNT_W  = 16;
  localparam int CTRL_W = 3;

  // control word bit positions
  localparam int OUT_EN_BIT = 0;
  localparam int INIT_BIT   = 1;
  localparam int ABRUPT_BIT = 2;

  // field selector inside a channel's four-word window
  localparam logic [1:0] F_CTRL   = 2'd0;
  localparam logic [1:0] F_DUTY   = 2'd1;
  localparam logic [1:0] F_PERIOD = 2'd2;
  localparam logic [1:0] F_COUNT  = 2'd3;

  typedef struct packed {
    logic abrupt;
    logic init_high;
    logic out_en;
  } chan_ctrl_t;

  // value the counter takes on a tick
  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cnt,
                                                  input logic [CNT_W-1:0] period);
    if (cnt == period) return '0;
    return cnt + CNT_W'(1);
  endfunction

  // true while the count lies in the inverted (active) part of the period
  function automatic logic in_active(input logic [CNT_W-1:0] cnt,
                                     input logic [CNT_W-1:0] duty,
                                     input logic [CNT_W-1:0] period);
    return (cnt >= duty) && (cnt <= period);
  endfunction

  // pin level from the driving flag, the idle level and the phase
  function automatic logic pin_level(input logic drive, input logic init_high,
                                     input logic active);
    return drive ? (init_high ^ active) : init_high;
  endfunction

endpackage

// File: rtl/pwm_bank_decode.sv
module pwm_bank_decode
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int CH_BITS = 3,
  parameter int AW      = 6
) (
  input  logic [AW-1:0]                     addr,
  input  logic                              we,
  input  logic [NUM_CH-1:0][CTRL_W-1:0]     rd_ctrl,
  input  logic [NUM_CH-1:0][CNT_W-1:0]      rd_duty,
  input  logic [NUM_CH-1:0][CNT_W-1:0]      rd_period,
  input  logic [NUM_CH-1:0][CNT_W-1:0]      rd_cnt,
  input  logic [NUM_CH-1:0]                 rd_run,
  output logic [NUM_CH-1:0]                 wr_ctrl,
  output logic [NUM_CH-1:0]                 wr_duty,
  output logic [NUM_CH-1:0]                 wr_period,
  output logic [NUM_CH-1:0]                 wr_cnt,
  output logic                              set_we,
  output logic                              clr_we,
  output logic [CNT_W-1:0]                  rdata
);

  logic               is_glb;
  logic [CH_BITS-1:0] sel;
  logic [1:0]         fld;
  logic               sel_ok;
  logic               glb_set;
  logic               glb_clr;

  assign is_glb  = addr[AW-1];
  assign sel     = addr[CH_BITS+1:2];
  assign fld     = addr[1:0];
  assign sel_ok  = !is_glb && (32'(sel) < 32'(NUM_CH));
  assign glb_set = is_glb && (addr[AW-2:0] == '0);
  assign glb_clr = is_glb && (addr[AW-2:0] == (AW-1)'(1));

  assign set_we = we && glb_set;
  assign clr_we = we && glb_clr;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_wr
    logic hit;
    assign hit          = we && sel_ok && (sel == CH_BITS'(i));
    assign wr_ctrl[i]   = hit && (fld == F_CTRL);
    assign wr_duty[i]   = hit && (fld == F_DUTY);
    assign wr_period[i] = hit && (fld == F_PERIOD);
    assign wr_cnt[i]    = hit && (fld == F_COUNT);
  end

  always_comb begin
    rdata = '0;
    if (glb_set) begin
      rdata[NUM_CH-1:0] = rd_run;
    end else if (sel_ok) begin
      unique case (fld)
        F_CTRL:   rdata[CTRL_W-1:0] = rd_ctrl[sel];
        F_DUTY:   rdata = rd_duty[sel];
        F_PERIOD: rdata = rd_period[sel];
        default:  rdata = rd_cnt[sel];
      endcase
    end
  end

endmodule

// File: rtl/pwm_run_ctl.sv
module pwm_run_ctl #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [NUM_CH-1:0] mask,
  output logic [NUM_CH-1:0] run_q
);

  logic [NUM_CH-1:0] set_bits;
  logic [NUM_CH-1:0] clr_bits;

  assign set_bits = set_we ? mask : '0;
  assign clr_bits = clr_we ? mask : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= (run_q | set_bits) & ~clr_bits;
  end

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic             wr_duty,
  input  logic             wr_period,
  input  logic             wr_cnt,
  input  logic [CNT_W-1:0] wdata,
  input  logic             tick,
  input  logic             running,
  output chan_ctrl_t       ctrl_q,
  output logic [CNT_W-1:0] duty_q,
  output logic [CNT_W-1:0] period_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             drive,
  output logic             active
);

  logic step;
  logic wrap_evt;
  logic soft_off;
  logic drain_q;
  logic stop_drain;

  assign step     = running && tick;
  assign wrap_evt = step && (cnt_q == period_q);
  // enable cleared without abrupt select on a live channel: finish the period
  assign soft_off = wr_ctrl && ctrl_q.out_en && running &&
                    !wdata[OUT_EN_BIT] && !wdata[ABRUPT_BIT];
  assign stop_drain = wr_ctrl && (wdata[OUT_EN_BIT] || wdata[ABRUPT_BIT]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      duty_q   <= '0;
      period_q <= '0;
    end else begin
      if (wr_ctrl)   ctrl_q   <= chan_ctrl_t'(wdata[CTRL_W-1:0]);
      if (wr_duty)   duty_q   <= wdata;
      if (wr_period) period_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (wr_cnt) cnt_q <= wdata;
    else if (step)   cnt_q <= next_count(cnt_q, period_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          drain_q <= 1'b0;
    else if (!running)   drain_q <= 1'b0;
    else if (wrap_evt)   drain_q <= 1'b0;
    else if (soft_off)   drain_q <= 1'b1;
    else if (stop_drain) drain_q <= 1'b0;
  end

  assign drive  = ctrl_q.out_en || drain_q;
  assign active = in_active(cnt_q, duty_q, period_q);

endmodule

// File: rtl/pwm_timer_bank.sv
module pwm_timer_bank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int CH_BITS = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  parameter int AW      = CH_BITS + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  input  logic              bus_we,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic [NUM_CH-1:0] tick,
  output logic [NUM_CH-1:0] pwm_out
);

  logic [NUM_CH-1:0][CTRL_W-1:0] ctrl_v;
  logic [NUM_CH-1:0][CNT_W-1:0]  duty_v;
  logic [NUM_CH-1:0][CNT_W-1:0]  period_v;
  logic [NUM_CH-1:0][CNT_W-1:0]  cnt_v;
  logic [NUM_CH-1:0]             init_v;
  logic [NUM_CH-1:0]             drive_v;
  logic [NUM_CH-1:0]             active_v;
  logic [NUM_CH-1:0]             ctrl_wr;
  logic [NUM_CH-1:0]             duty_wr;
  logic [NUM_CH-1:0]             period_wr;
  logic [NUM_CH-1:0]             cnt_wr;
  logic [NUM_CH-1:0]             run_q;
  logic                          set_we;
  logic                          clr_we;

  pwm_bank_decode #(.NUM_CH(NUM_CH), .CH_BITS(CH_BITS), .AW(AW)) u_dec (
    .addr      (bus_addr),
    .we        (bus_we),
    .rd_ctrl   (ctrl_v),
    .rd_duty   (duty_v),
    .rd_period (period_v),
    .rd_cnt    (cnt_v),
    .rd_run    (run_q),
    .wr_ctrl   (ctrl_wr),
    .wr_duty   (duty_wr),
    .wr_period (period_wr),
    .wr_cnt    (cnt_wr),
    .set_we    (set_we),
    .clr_we    (clr_we),
    .rdata     (bus_rdata)
  );

  pwm_run_ctl #(.NUM_CH(NUM_CH)) u_run (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_we (set_we),
    .clr_we (clr_we),
    .mask   (bus_wdata[NUM_CH-1:0]),
    .run_q  (run_q)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    chan_ctrl_t ctrl_s;

    pwm_chan u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_ctrl   (ctrl_wr[i]),
      .wr_duty   (duty_wr[i]),
      .wr_period (period_wr[i]),
      .wr_cnt    (cnt_wr[i]),
      .wdata     (bus_wdata),
      .tick      (tick[i]),
      .running   (run_q[i]),
      .ctrl_q    (ctrl_s),
      .duty_q    (duty_v[i]),
      .period_q  (period_v[i]),
      .cnt_q     (cnt_v[i]),
      .drive     (drive_v[i]),
      .active    (active_v[i])
    );

    assign ctrl_v[i]  = ctrl_s;
    assign init_v[i]  = ctrl_s.init_high;
    assign pwm_out[i] = pin_level(drive_v[i], init_v[i], active_v[i]);
  end

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int AW     = 6
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [AW-1:0]                bus_addr,
  input logic [CNT_W-1:0]             bus_wdata,
  input logic                         bus_we,
  input logic [NUM_CH-1:0]            tick,
  input logic [NUM_CH-1:0]            pwm_out,
  input logic [NUM_CH-1:0]            run_q,
  input logic [NUM_CH-1:0][CNT_W-1:0] cnt_v,
  input logic [NUM_CH-1:0][CNT_W-1:0] duty_v,
  input logic [NUM_CH-1:0][CNT_W-1:0] period_v,
  input logic [NUM_CH-1:0]            init_v,
  input logic [NUM_CH-1:0]            drive_v,
  input logic [NUM_CH-1:0]            cnt_wr,
  input logic [NUM_CH-1:0]            ctrl_wr
);

  localparam logic [AW-1:0] SET_ADDR = AW'(1) << (AW - 1);

  // R2
  run_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == SET_ADDR) |=>
      ((run_q & $past(bus_wdata[NUM_CH-1:0])) == $past(bus_wdata[NUM_CH-1:0])));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R3
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((!run_q[i] || !tick[i]) && !cnt_wr[i]) |=> $stable(cnt_v[i]));

    // R4
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q[i] && tick[i] && !cnt_wr[i] && cnt_v[i] == period_v[i]) |=> (cnt_v[i] == '0));

    // R7
    parked_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !drive_v[i] |-> (pwm_out[i] == init_v[i]));

    // R8
    abrupt_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr[i] && !bus_wdata[OUT_EN_BIT] && bus_wdata[ABRUPT_BIT]) |=>
        (pwm_out[i] == $past(bus_wdata[INIT_BIT])));

    // R9
    duty_over_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (duty_v[i] > period_v[i] && cnt_v[i] <= period_v[i]) |-> (pwm_out[i] == init_v[i]));
  end

endmodule

bind pwm_timer_bank pwm_bank_chk #(.NUM_CH(NUM_CH), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_we    (bus_we),
  .tick      (tick),
  .pwm_out   (pwm_out),
  .run_q     (run_q),
  .cnt_v     (cnt_v),
  .duty_v    (duty_v),
  .period_v  (period_v),
  .init_v    (init_v),
  .drive_v   (drive_v),
  .cnt_wr    (cnt_wr),
  .ctrl_wr   (ctrl_wr)
);

// File: tb/sim_pwm_timer_bank.sv
module sim_pwm_timer_bank;

  localparam int CLK_PERIOD = 10;
  localparam int NCH   = 8;
  localparam int AW    = 6;
  localparam int SET_A = 32;
  localparam int CLR_A = 33;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [AW-1:0]    bus_addr = '0;
  logic [15:0]      bus_wdata = '0;
  logic             bus_we = 1'b0;
  logic [15:0]      bus_rdata;
  logic [NCH-1:0]   tick = '0;
  logic [NCH-1:0]   pwm_out;

  typedef struct {
    int    kind;   // 0: one pin, 1: read data, 2: all pins
    int    idx;
    int    expv;
    string tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  pwm_timer_bank u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .tick      (tick),
    .pwm_out   (pwm_out)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int a_of(int ch, int f);
    return ch * 4 + f;
  endfunction

  // monitor: compare every queued expectation at the falling edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      int act;
      it = q.pop_front();
      case (it.kind)
        0:       act = int'(pwm_out[it.idx]);
        1:       act = int'(bus_rdata);
        default: act = int'(pwm_out);
      endcase
      checks++;
      if (act != it.expv) begin
        errors++;
        $display("FAIL %s: actual=%0h expected=%0h", it.tag, act, it.expv);
      end
    end
  end

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(int a, int d);
    bus_addr  = AW'(a);
    bus_wdata = 16'(d);
    bus_we    = 1'b1;
    cyc();
    bus_we    = 1'b0;
  endtask

  task automatic pulse(int mask);
    tick = NCH'(mask);
    cyc();
    tick = '0;
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic exp_pin(int ch, int v, string tag);
    item_t it;
    it.kind = 0; it.idx = ch; it.expv = v; it.tag = tag;
    q.push_back(it);
    settle();
  endtask

  task automatic exp_rd(int a, int v, string tag);
    item_t it;
    bus_addr = AW'(a);
    it.kind = 1; it.idx = a; it.expv = v; it.tag = tag;
    q.push_back(it);
    settle();
  endtask

  task automatic exp_all(int v, string tag);
    item_t it;
    it.kind = 2; it.idx = 0; it.expv = v; it.tag = tag;
    q.push_back(it);
    settle();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();

    // R1 reset state
    exp_rd(SET_A, 0, "R1 run status");
    exp_rd(a_of(0, 2), 0, "R1 period ch0");
    exp_rd(a_of(7, 0), 0, "R1 ctrl ch7");
    exp_all(0, "R1 pins low");

    // R11 readback after configuration
    wr(a_of(0, 1), 2);
    wr(a_of(0, 2), 4);
    wr(a_of(0, 0), 1);
    exp_rd(a_of(0, 1), 2, "R11 duty");
    exp_rd(a_of(0, 2), 4, "R11 period");
    exp_rd(a_of(0, 0), 1, "R11 ctrl");

    // R2 set/clear strobes
    wr(SET_A, 5);
    exp_rd(SET_A, 5, "R2 set ch0,ch2");
    wr(CLR_A, 4);
    exp_rd(SET_A, 1, "R2 clear ch2 only");

    // R5 low idle level, duty 2 period 4; R4 wrap
    exp_pin(0, 0, "R5 cnt0");
    pulse(1); exp_rd(a_of(0, 3), 1, "R3 one step"); exp_pin(0, 0, "R5 cnt1");
    pulse(1); exp_pin(0, 1, "R5 cnt2 duty match");
    pulse(1); exp_pin(0, 1, "R5 cnt3");
    pulse(1); exp_pin(0, 1, "R5 cnt4 period");
    pulse(1); exp_rd(a_of(0, 3), 0, "R4 wrap count"); exp_pin(0, 0, "R4 wrap pin");

    // R3 no tick, foreign tick
    cyc(); cyc();
    pulse(2);
    exp_rd(a_of(0, 3), 0, "R3 hold without own tick");

    // R6 high idle level
    wr(a_of(0, 0), 3);
    exp_pin(0, 1, "R6 high idle at cnt0");
    pulse(1); pulse(1);
    exp_pin(0, 0, "R6 inverted active at cnt2");

    // R8 soft shutdown drains until wrap
    pulse(1);
    exp_pin(0, 0, "R8 cnt3 before soft off");
    wr(a_of(0, 0), 2);
    exp_pin(0, 0, "R8 soft off keeps toggling");
    pulse(1); exp_pin(0, 0, "R8 soft off cnt4");
    pulse(1); exp_pin(0, 1, "R8 parked at wrap");
    pulse(1); pulse(1);
    exp_pin(0, 1, "R7 disabled in active phase");

    // R8 abrupt shutdown
    wr(a_of(0, 0), 1);
    exp_pin(0, 1, "R8 re-enabled cnt2");
    pulse(1);
    exp_pin(0, 1, "R8 cnt3 active");
    wr(a_of(0, 0), 4);
    exp_pin(0, 0, "R8 abrupt parks at once");

    // R3 stopped counter holds
    wr(CLR_A, 1);
    exp_rd(SET_A, 0, "R2 stop ch0");
    pulse(1); pulse(1);
    exp_rd(a_of(0, 3), 3, "R3 stopped holds");

    // R10 counter writes
    wr(a_of(0, 0), 1);
    wr(a_of(0, 3), 1);
    exp_rd(a_of(0, 3), 1, "R10 write count 1");
    exp_pin(0, 0, "R10 pin at cnt1");
    wr(a_of(0, 3), 3);
    exp_pin(0, 1, "R10 pin at cnt3");
    wr(a_of(0, 3), 0);
    exp_rd(a_of(0, 3), 0, "R10 restart at 0");
    exp_pin(0, 0, "R10 pin after restart");
    wr(SET_A, 1);
    pulse(1);
    exp_rd(a_of(0, 3), 1, "R10 counts from 0");

    // R9 duty above period
    wr(a_of(0, 1), 5);
    for (int k = 0; k < 5; k++) begin
      pulse(1);
      exp_pin(0, 0, "R9 idle level whole period");
    end
    exp_rd(a_of(0, 3), 1, "R9 count after five steps");

    // R4 shorter period, duty 0
    wr(a_of(0, 1), 0);
    wr(a_of(0, 2), 2);
    exp_pin(0, 1, "R5 duty 0 active at cnt1");
    pulse(1); exp_rd(a_of(0, 3), 2, "R4 reach period 2");
    pulse(1); exp_rd(a_of(0, 3), 0, "R4 wrap at period 2");
    exp_pin(0, 1, "R5 duty 0 active at cnt0");

    cyc();
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule